// File: doc/BRIEF.md
# Multichannel Sync Loss Monitor

The block watches the horizontal sync strobes of eight video inputs and tells a host which inputs have stopped delivering sync. Each input arrives as a digital strobe. It may be asynchronous to the block clock, so it passes through a two-stage synchronizer and a rising-edge detector. Every detected rising edge restarts a per-channel timer. A timer that runs past one horizontal line period, plus a small margin, with no new edge raises that channel's loss flag.

The eight flags form one 8-bit status word, with channel N in bit N. When every input carries sync, the word is all zeros. A host polls the word through a simple read strobe and treats any nonzero bit as lost video on that channel. The flags show live status and are not latched. A flag drops by itself once edges return on its input. After reset every timer starts in the expired state, so each flag reads set until that channel sees its first edge.

Top module: `sync_loss_monitor`

## Requirements
- R1: After reset, every flag is set, and the first read returns 8'hFF while no sync edge has arrived.
- R2: Bit N of the status word belongs to input N, for N from 0 to 7.
- R3: When every input receives a rising edge at least once per line period, the status word reads 8'h00.
- R4: With LIMIT = LINE_CYCLES + MARGIN_CYCLES, a flag is set only after its timer has counted LIMIT+1 edges since its last restart. A read issued LIMIT+2 idle cycles after a strobe shows the flag clear, and one issued LIMIT+3 idle cycles after shows it set.
- R5: A flag clears by itself when an edge arrives. The timer restarts on the second clock edge after the strobe is first sampled. A read one idle cycle after the strobe still shows the old flag, and a read two idle cycles after shows it clear.
- R6: Only a rising edge of a strobe restarts its timer. An input held high expires like an input held low.
- R7: Channels are independent. A strobe on one input never changes the flag of another.
- R8: A read strobe high at a clock edge loads the status word into the read data at that edge. While the read strobe is low, the read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 8 | Horizontal sync strobes, one per channel; bit N is channel N |
| rdEn | input | 1 | Host read strobe |
| rdData | output | 8 | Status word captured by the last read; 1 means sync lost |

## Verification
A read captures the flags as they stand just before the clock edge at which the read strobe is high. The result therefore appears one edge after the read is issued. A strobe is first sampled at edge k and restarts its timer at edge k+2. The bench counts clock edges and records the restart edge of every channel. From that record it derives each expected flag for the exact edge a read samples. The R4 and R5 boundaries are probed by idle gaps one cycle apart on either side of the threshold.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;
  localparam int NUM_CH = 8;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic [NUM_CH-1:0] restart;  // rising edge seen on a channel
    logic              capture;  // host read: load status into read data
  } monStrobes_t;
endpackage

// File: rtl/sync_mon_ctrl.sv
module sync_mon_ctrl
  import sync_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] syncIn,
  input  logic              rdEn,
  output monStrobes_t       strobes
);

  logic [NUM_CH-1:0] stage1, stage2, stage3;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_chan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage1[gi] <= 1'b0;
          stage2[gi] <= 1'b0;
          stage3[gi] <= 1'b0;
        end else begin
          stage1[gi] <= syncIn[gi];
          stage2[gi] <= stage1[gi];
          stage3[gi] <= stage2[gi];
        end
      end

      assign strobes.restart[gi] = stage2[gi] & ~stage3[gi];

      // R6: an edge produces a single-cycle restart
      p_edge_single_r6: assert property (@(posedge clk) disable iff (!rstN)
        strobes.restart[gi] |=> !strobes.restart[gi]);

      // R6: a restart needs the input to have been high two edges earlier
      p_edge_source_r6: assert property (@(posedge clk) disable iff (!rstN)
        strobes.restart[gi] |-> $past(syncIn[gi], 2));
    end
  endgenerate

  assign strobes.capture = rdEn;

endmodule

// File: rtl/sync_mon_dp.sv
module sync_mon_dp
  import sync_mon_pkg::*;
#(
  parameter int LINE_CYCLES   = 1716,
  parameter int MARGIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobes_t       strobes,
  output logic [NUM_CH-1:0] rdData
);

  localparam int LIMIT = LINE_CYCLES + MARGIN_CYCLES;
  localparam int CW    = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] EXPIRED = CW'(LIMIT + 1);

  logic [CW-1:0]     age [NUM_CH];
  logic [NUM_CH-1:0] lossFlags;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_timer
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          age[gi] <= EXPIRED;
        end else if (strobes.restart[gi]) begin
          age[gi] <= '0;
        end else if (age[gi] != EXPIRED) begin
          age[gi] <= age[gi] + 1'b1;
        end
      end

      assign lossFlags[gi] = (age[gi] == EXPIRED);

      // R5: a restart leaves the flag clear on the next cycle
      p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
        strobes.restart[gi] |=> !lossFlags[gi]);

      // R4: a flag can only rise when no restart arrived in the previous cycle
      p_rise_no_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
        $rose(lossFlags[gi]) |-> !$past(strobes.restart[gi]));

      // R4: once the timer has expired it stays expired without an edge
      p_stay_set_r4: assert property (@(posedge clk) disable iff (!rstN)
        (lossFlags[gi] && !strobes.restart[gi]) |=> lossFlags[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.capture) begin
      rdData <= lossFlags;
    end
  end

  // R8: read data holds without a read strobe
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(rdData));

  // R8: a read loads the flags seen at that edge
  p_rd_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> rdData == $past(lossFlags));

endmodule

// File: rtl/sync_loss_monitor.sv
module sync_loss_monitor
  import sync_mon_pkg::*;
#(
  parameter int LINE_CYCLES   = 1716,
  parameter int MARGIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] syncIn,
  input  logic       rdEn,
  output logic [7:0] rdData
);

  monStrobes_t strobes;

  sync_mon_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  sync_mon_dp #(
    .LINE_CYCLES   (LINE_CYCLES),
    .MARGIN_CYCLES (MARGIN_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdData  (rdData)
  );

endmodule

// File: tb/sim_sync_loss_monitor.sv
`timescale 1ns/1ps
module sim_sync_loss_monitor;
  localparam int LINE  = 20;
  localparam int MARG  = 2;
  localparam int LIMIT = LINE + MARG;
  localparam int NV    = 8;

  localparam logic [7:0] VEC_MASK [NV] = '{8'hFF, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h00, 8'h81, 8'h3C};
  localparam int         VEC_GAP  [NV] = '{2, 12, 14, 1, 20, 30, 5, 26};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] syncIn = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  bit finished = 1'b0;

  int restartEdge [8];
  int prevRestart [8];
  bit seen [8];
  bit prevSeen [8];

  always #2.5 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  sync_loss_monitor #(.LINE_CYCLES(LINE), .MARGIN_CYCLES(MARG)) u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .rdEn(rdEn), .rdData(rdData)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // record a restart two edges after the first sampling edge
  task automatic noteEdge(input logic [7:0] mask);
    int k = edgeCnt + 1;
    for (int c = 0; c < 8; c++) begin
      if (mask[c]) begin
        prevRestart[c] = restartEdge[c];
        prevSeen[c]    = seen[c];
        restartEdge[c] = k + 2;
        seen[c]        = 1'b1;
      end
    end
  endtask

  task automatic pulse(input logic [7:0] mask);
    syncIn = mask;
    noteEdge(mask);
    @(negedge clk);
    syncIn = 8'h00;
  endtask

  function automatic logic [7:0] model(input int r);
    logic [7:0] v;
    int t = r - 1;
    for (int c = 0; c < 8; c++) begin
      if (seen[c] && restartEdge[c] <= t)
        v[c] = (t - restartEdge[c]) >= LIMIT + 1;
      else if (prevSeen[c] && prevRestart[c] <= t)
        v[c] = (t - prevRestart[c]) >= LIMIT + 1;
      else
        v[c] = 1'b1;
    end
    return v;
  endfunction

  task automatic readStatus(output logic [7:0] val, output logic [7:0] exp);
    int r;
    rdEn = 1'b1;
    r = edgeCnt + 1;
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
    exp = model(r);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, exp, held;
    for (int c = 0; c < 8; c++) begin
      seen[c] = 0; prevSeen[c] = 0; restartEdge[c] = 0; prevRestart[c] = 0;
    end
    idle(4);
    check("R8 reset read data", rdData, 8'h00);
    rstN = 1'b1;
    idle(2);

    // R1: all flags set after reset
    readStatus(got, exp);
    check("R1 reset flags", got, 8'hFF);

    // Vector walk: R2 R3 R7 against the edge-count model
    for (int i = 0; i < NV; i++) begin
      pulse(VEC_MASK[i]);
      idle(VEC_GAP[i]);
      readStatus(got, exp);
      check("R2 R3 R7 vector", got, exp);
    end

    // R3: regular edges on all inputs keep the word at zero
    for (int i = 0; i < 4; i++) begin
      pulse(8'hFF);
      idle(LINE - 4);
    end
    readStatus(got, exp);
    check("R3 steady sync", got, 8'h00);

    // R4: threshold boundary
    pulse(8'hFF);
    idle(LIMIT + 2);
    readStatus(got, exp);
    check("R4 just before timeout", got, 8'h00);
    pulse(8'hFF);
    idle(LIMIT + 3);
    readStatus(got, exp);
    check("R4 at timeout", got, 8'hFF);

    // R5: flag clears on its own with two-edge latency
    pulse(8'h01);
    idle(1);
    readStatus(got, exp);
    check("R5 one cycle after strobe", got, 8'hFF);
    pulse(8'h01);
    idle(2);
    readStatus(got, exp);
    check("R5 two cycles after strobe", got, 8'hFE);

    // R2 R7: single channel 7 only touches bit 7
    idle(LIMIT + 3);
    pulse(8'h80);
    idle(3);
    readStatus(got, exp);
    check("R2 R7 channel seven", got, 8'h7F);

    // R6: a held-high input expires
    idle(LIMIT + 3);
    syncIn = 8'h01;
    noteEdge(8'h01);
    idle(LIMIT + 6);
    readStatus(got, exp);
    check("R6 held high expires", got, 8'hFF);
    syncIn = 8'h00;
    idle(4);
    readStatus(got, exp);
    check("R6 falling edge ignored", got, 8'hFF);

    // R8: read data holds while no read is issued
    held = got;
    pulse(8'hFF);
    idle(6);
    check("R8 hold without read", rdData, held);
    readStatus(got, exp);
    check("R8 new read loads", got, 8'h00);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule